// File: doc/BRIEF.md
# Prescaled Two-Stage Watchdog

This block guards a processor against a stalled program. It counts periods of a slow watchdog time base through a chain of counters: an optional divide-by-16 prescaler, a reloading scaler and a main down-counter. When the main counter runs out, the block gives a one-cycle timeout interrupt. The same counter is then reloaded with a grace value. If software does not rewrite the program word before the grace period ends, the block raises a warm-reset request and holds it.

Software writes one program word. The word sets the timeout, scaler and grace presets, restarts the timeout phase and acknowledges a pending timeout. A separate write-anything strobe can switch the watchdog off, but only before its first timeout since reset. Once off, it stays off until the program word is written again. The watchdog time base arrives as a one-cycle tick strobe in the system clock domain. The tick must already be synchronised by the clock-crossing handshake that delivers it. The block counts those ticks.

Top module: `wdt_top`

## Requirements
- R1: After reset, both outputs are low and the watchdog runs with all-ones presets. With the divider off, the first interrupt comes after 2^SCL_W × 2^CNT_W ticks. The reset request follows 2^SCL_W × 2^RST_W ticks later.
- R2: The program word packs the timeout preset C in bits [CNT_W-1:0], the scaler preset S in the next SCL_W bits and the grace preset G in the top RST_W bits. A write loads all three presets, restarts the prescaler and starts a new timeout phase.
- R3: After a program write, timeout_irq is high for exactly one cycle. It rises in the cycle after the P × (S+1) × (C+1)-th tick. P is 16 when div16_en is 1 and 1 otherwise.
- R4: If no program write follows, warm_reset_req rises after a further P × (S+1) × (G+1) ticks. It stays high until rst_n is driven low. While it is high, program writes are ignored and no interrupt is raised.
- R5: Only cycles with wd_tick high advance the counters. div16_en selects the factor P of 16 or 1.
- R6: A program write during the grace period acknowledges the timeout. No reset request follows, and the next interrupt comes after the full timeout of the new presets.
- R7: A trap_we strobe before the first timeout since reset disables the watchdog: neither output rises, however many ticks follow. The next program write re-enables the watchdog with R3 timing.
- R8: Once a timeout has occurred since reset, a trap_we strobe has no effect. The reset request or the next interrupt still comes on schedule.
- R9: When prog_we and trap_we are high in the same cycle, the program write takes effect and the trap strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_tick | input | 1 | One-cycle watchdog time-base strobe |
| div16_en | input | 1 | 1 selects the divide-by-16 prescaler |
| prog_we | input | 1 | Program word write strobe |
| prog_word | input | CNT_W+SCL_W+RST_W | Program word: timeout, scaler and grace presets |
| trap_we | input | 1 | Write-anything disable strobe |
| timeout_irq | output | 1 | One-cycle timeout interrupt |
| warm_reset_req | output | 1 | Sticky warm-reset request |

## Verification
A wrong count in the prescaler, scaler or main counter does not show until the next timeout. It then appears as an interrupt or reset request early or late by a whole multiple of a stage period. The bench therefore measures the tick count at which each output rises, rather than sampling at fixed times. A wrong phase or trap-door flag shows as a missing or extra output edge. This can happen as much as a full timeout after the strobe that caused it, so each scenario runs past both deadlines before it is judged.

// File: rtl/wdt_pkg.sv
// Package: shared types for the prescaled watchdog.
package wdt_pkg;
    // Phase of the watchdog controller.
    typedef enum logic [1:0] {
        WD_RUN   = 2'd0,   // counting towards the timeout interrupt
        WD_GRACE = 2'd1,   // timeout seen, counting towards warm reset
        WD_OFF   = 2'd2,   // disabled through the trap door
        WD_FIRED = 2'd3    // warm reset requested, held until reset
    } wd_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Passes watchdog ticks to the scaler, either every tick or every
// 2**PRE_LOG2-th tick. Assumes wd_tick is a one-cycle strobe already
// synchronised to clk. restart clears the phase and takes priority.
module wdt_prescaler #(
    parameter int PRE_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic div_en,
    input  logic active,
    input  logic restart,
    output logic stage_tick
);
    logic [PRE_LOG2-1:0] phase_q;

    // A stage tick leaves on every tick, or on the last tick of each divided group.
    always_comb begin
        stage_tick = active && tick && !restart && (!div_en || (&phase_q));
    end

    // Phase counter of the divider, cleared by a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (active && tick && div_en) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    AST_PRE_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0)); // R2
    AST_PRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase_q) || $past(restart)); // R5
endmodule

// File: rtl/wdt_scaler.sv
// Module: wdt_scaler
// Down-counter that is stepped by the prescaler. It reloads from the
// scaler preset after reaching zero, and each reload emits one wrap
// that steps the main counter. load starts it from a new preset.
module wdt_scaler #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [SCL_W-1:0] load_val,
    input  logic [SCL_W-1:0] reload_val,
    output logic             wrap
);
    logic [SCL_W-1:0] cnt_q;

    // A wrap happens when a step finds the counter already at zero.
    always_comb begin
        wrap = step && !load && (cnt_q == '0);
    end

    // Count down, reload after zero, or take a new start value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
        end
    end

    AST_SCL_WITHIN_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= reload_val); // R2
    AST_SCL_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == $past(reload_val)) || $past(load)); // R3
endmodule

// File: rtl/wdt_ctrl.sv
// Module: wdt_ctrl
// Holds the presets and the main down-counter, and runs the phase
// sequence timeout -> grace -> reset request. It also decides whether a
// program write or a trap-door strobe is accepted. One counter serves
// both the timeout phase and the grace phase.
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8,
    parameter int RST_W = 8,
    localparam int PW   = CNT_W + SCL_W + RST_W,
    localparam int MW   = (CNT_W > RST_W) ? CNT_W : RST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_we,
    input  logic [PW-1:0]    prog_word,
    input  logic             trap_we,
    input  logic             wrap,
    output logic             active,
    output logic             restart,
    output logic [SCL_W-1:0] scl_preset,
    output logic [SCL_W-1:0] scl_load,
    output logic             irq,
    output logic             reset_req
);
    localparam int S_LO = CNT_W;
    localparam int G_LO = CNT_W + SCL_W;

    wd_state_e        state_q;
    logic [CNT_W-1:0] c_preset_q;
    logic [SCL_W-1:0] s_preset_q;
    logic [RST_W-1:0] g_preset_q;
    logic [MW-1:0]    main_q;
    logic             fired_once_q;
    logic             irq_q;
    logic             req_q;
    logic             prog_ok;
    logic             trap_ok;
    logic [CNT_W-1:0] f_c;
    logic [SCL_W-1:0] f_s;
    logic [RST_W-1:0] f_g;

    // Split the program word into its three preset fields.
    always_comb begin
        f_c = prog_word[CNT_W-1:0];
        f_s = prog_word[S_LO +: SCL_W];
        f_g = prog_word[G_LO +: RST_W];
    end

    // Acceptance rules: a program write wins; the trap door only works before the first timeout.
    always_comb begin
        prog_ok = prog_we && (state_q != WD_FIRED);
        trap_ok = trap_we && !prog_we && (state_q == WD_RUN) && !fired_once_q;
    end

    // Control outputs towards the prescaler and scaler.
    always_comb begin
        active     = (state_q == WD_RUN) || (state_q == WD_GRACE);
        restart    = prog_ok;
        scl_preset = s_preset_q;
        scl_load   = f_s;
        irq        = irq_q;
        reset_req  = req_q;
    end

    // Presets, main counter, phase and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_preset_q   <= '1;
            s_preset_q   <= '1;
            g_preset_q   <= '1;
            main_q       <= MW'({CNT_W{1'b1}});
            state_q      <= WD_RUN;
            fired_once_q <= 1'b0;
            irq_q        <= 1'b0;
            req_q        <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (prog_ok) begin
                c_preset_q <= f_c;
                s_preset_q <= f_s;
                g_preset_q <= f_g;
                main_q     <= MW'(f_c);
                state_q    <= WD_RUN;
            end else if (trap_ok) begin
                state_q <= WD_OFF;
            end else if (wrap && active) begin
                if (main_q != '0) begin
                    main_q <= main_q - 1'b1;
                end else if (state_q == WD_RUN) begin
                    irq_q        <= 1'b1;
                    fired_once_q <= 1'b1;
                    main_q       <= MW'(g_preset_q);
                    state_q      <= WD_GRACE;
                end else begin
                    req_q   <= 1'b1;
                    state_q <= WD_FIRED;
                end
            end
        end
    end

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R3
    AST_IRQ_ENTERS_GRACE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (state_q == WD_GRACE) && fired_once_q); // R3
    AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> req_q); // R4
    AST_FIRED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRED) |=> (state_q == WD_FIRED) && !irq_q); // R4
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_OFF) |=> !irq_q && !req_q); // R7
    AST_TRAP_LATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_we && !prog_we && fired_once_q) |=> (state_q != WD_OFF)); // R8
    AST_PROG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && trap_we && (state_q != WD_FIRED)) |=> (state_q == WD_RUN)); // R9
    AST_PROG_LOADS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |=> (main_q == MW'($past(f_c)))); // R2
endmodule

// File: rtl/wdt_top.sv
// Module: wdt_top
// Prescaled two-stage watchdog: prescaler -> scaler -> controller with
// the main counter. Assumes wd_tick is a clk-synchronous strobe that
// marks one period of the watchdog time base.
module wdt_top #(
    parameter int PRE_LOG2 = 4,
    parameter int CNT_W    = 16,
    parameter int SCL_W    = 8,
    parameter int RST_W    = 8,
    localparam int PW      = CNT_W + SCL_W + RST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wd_tick,
    input  logic          div16_en,
    input  logic          prog_we,
    input  logic [PW-1:0] prog_word,
    input  logic          trap_we,
    output logic          timeout_irq,
    output logic          warm_reset_req
);
    logic             active;
    logic             restart;
    logic             stage_tick;
    logic             wrap;
    logic [SCL_W-1:0] scl_preset;
    logic [SCL_W-1:0] scl_load;

    wdt_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (wd_tick),
        .div_en     (div16_en),
        .active     (active),
        .restart    (restart),
        .stage_tick (stage_tick)
    );

    wdt_scaler #(.SCL_W(SCL_W)) u_scl (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (stage_tick),
        .load       (restart),
        .load_val   (scl_load),
        .reload_val (scl_preset),
        .wrap       (wrap)
    );

    wdt_ctrl #(.CNT_W(CNT_W), .SCL_W(SCL_W), .RST_W(RST_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .prog_word  (prog_word),
        .trap_we    (trap_we),
        .wrap       (wrap),
        .active     (active),
        .restart    (restart),
        .scl_preset (scl_preset),
        .scl_load   (scl_load),
        .irq        (timeout_irq),
        .reset_req  (warm_reset_req)
    );

    AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_irq && warm_reset_req)); // R4
endmodule

// File: tb/test_wdt_top.sv
// Bench for wdt_top with narrow counters so the all-ones reset presets fit in a short run.
module test_wdt_top;
    localparam int CW = 4;
    localparam int SW = 2;
    localparam int GW = 2;
    localparam int PW = CW + SW + GW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wd_tick = 1'b0;
    logic          div16_en = 1'b0;
    logic          prog_we = 1'b0;
    logic [PW-1:0] prog_word = '0;
    logic          trap_we = 1'b0;
    logic          timeout_irq;
    logic          warm_reset_req;

    int n_checks = 0;
    int n_fail   = 0;

    wdt_top #(.PRE_LOG2(4), .CNT_W(CW), .SCL_W(SW), .RST_W(GW)) i_wdt_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .wd_tick        (wd_tick),
        .div16_en       (div16_en),
        .prog_we        (prog_we),
        .prog_word      (prog_word),
        .trap_we        (trap_we),
        .timeout_irq    (timeout_irq),
        .warm_reset_req (warm_reset_req)
    );

    always #10 clk = ~clk;

    function automatic int t_irq(input bit p, input int s, input int c);
        return (p ? 16 : 1) * (s + 1) * (c + 1);
    endfunction

    function automatic int t_grace(input bit p, input int s, input int g);
        return (p ? 16 : 1) * (s + 1) * (g + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wd_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic prog(input int c, input int s, input int g, input bit with_trap);
        prog_word = {GW'(g), SW'(s), CW'(c)};
        prog_we = 1'b1;
        trap_we = with_trap;
        @(negedge clk);
        prog_we = 1'b0;
        trap_we = 1'b0;
    endtask

    task automatic trap();
        trap_we = 1'b1;
        @(negedge clk);
        trap_we = 1'b0;
    endtask

    // Deliver n ticks at random cycles; report the tick count at each output's first rise.
    task automatic run_ticks(input int n, output int irq_at, output int rst_at, output int irq_cnt);
        int cnt = 0;
        irq_at = -1;
        rst_at = -1;
        irq_cnt = 0;
        while (cnt < n) begin
            bit tk;
            tk = ($urandom % 4) != 0;
            wd_tick = tk;
            @(negedge clk);
            cnt += int'(tk);
            if (timeout_irq) begin
                irq_cnt++;
                if (irq_at < 0) irq_at = cnt;
            end
            if (warm_reset_req && rst_at < 0) rst_at = cnt;
        end
        wd_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual not done expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int ia, ra, ic, ti, tg;
        void'($urandom(32'h1234_5eed));

        // R1: reset state and the default all-ones presets.
        do_reset();
        chk("R1 irq after reset", int'(timeout_irq), 0);
        chk("R1 req after reset", int'(warm_reset_req), 0);
        run_ticks(64 + 16 + 5, ia, ra, ic);
        chk("R1 default timeout", ia, 64);
        chk("R1 default reset", ra, 80);

        // R4: sticky request, program writes ignored, cleared by reset.
        prog(1, 0, 0, 1'b0);
        run_ticks(40, ia, ra, ic);
        chk("R4 no irq while fired", ic, 0);
        chk("R4 req held", int'(warm_reset_req), 1);
        do_reset();
        chk("R4 req cleared by reset", int'(warm_reset_req), 0);

        // R2 R3 R5: random presets and divider setting.
        for (int k = 0; k < 18; k++) begin
            int c, s, g;
            bit p;
            c = $urandom % 16;
            s = $urandom % 4;
            g = $urandom % 4;
            p = (k % 3) == 0;
            do_reset();
            div16_en = p;
            prog(c, s, g, 1'b0);
            ti = t_irq(p, s, c);
            tg = t_grace(p, s, g);
            run_ticks(ti + tg + 3, ia, ra, ic);
            chk("R3 timeout tick count", ia, ti);
            chk("R3 single-cycle irq", ic, 1);
            chk("R4 grace tick count", ra - ia, tg);
            chk(p ? "R5 divide-by-16 timing" : "R2 preset fields", ra, ti + tg);
        end

        // R5: directed divider case with the smallest presets.
        do_reset();
        div16_en = 1'b1;
        prog(0, 0, 0, 1'b0);
        run_ticks(40, ia, ra, ic);
        chk("R5 divided minimum timeout", ia, 16);
        chk("R5 divided minimum reset", ra, 32);
        div16_en = 1'b0;

        // R6: acknowledge during the grace period.
        do_reset();
        prog(3, 1, 3, 1'b0);
        run_ticks(t_irq(0, 1, 3) + 3, ia, ra, ic);
        chk("R6 first timeout", ia, 8);
        chk("R6 no reset before ack", ra, -1);
        prog(2, 2, 0, 1'b0);
        run_ticks(t_irq(0, 2, 2) + t_grace(0, 2, 0) + 2, ia, ra, ic);
        chk("R6 timeout with new presets", ia, 9);
        chk("R6 reset with new presets", ra, 12);

        // R7: trap door before the first timeout.
        do_reset();
        prog(5, 3, 1, 1'b0);
        run_ticks(10, ia, ra, ic);
        trap();
        run_ticks(2000, ia, ra, ic);
        chk("R7 no irq while disabled", ic, 0);
        chk("R7 no reset while disabled", ra, -1);
        prog(1, 1, 1, 1'b0);
        run_ticks(10, ia, ra, ic);
        chk("R7 re-enabled timeout", ia, 4);
        chk("R7 re-enabled reset", ra, 8);

        // R8: trap strobe after the first timeout, in grace and after ack.
        do_reset();
        prog(2, 1, 3, 1'b0);
        run_ticks(8, ia, ra, ic);
        chk("R8 timeout before late trap", ia, 6);
        trap();
        run_ticks(10, ia, ra, ic);
        chk("R8 reset despite late trap", ra, 6);
        do_reset();
        prog(0, 0, 3, 1'b0);
        run_ticks(2, ia, ra, ic);
        chk("R8 first timeout", ia, 1);
        prog(2, 0, 0, 1'b0);
        trap();
        run_ticks(5, ia, ra, ic);
        chk("R8 irq despite trap after ack", ia, 3);
        chk("R8 reset despite trap after ack", ra, 4);

        // R9: simultaneous program write and trap strobe.
        do_reset();
        prog(3, 0, 1, 1'b1);
        run_ticks(8, ia, ra, ic);
        chk("R9 program wins timeout", ia, 4);
        chk("R9 program wins reset", ra, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule